// File: doc/BRIEF.md
# SPI master with register-driven select

This block is an SPI master shift engine for a register-mapped peripheral slot. Software or a DMA engine writes 8-bit characters into a transmit holding register. The engine shifts each one out on MOSI while it shifts a character in from MISO. The slave-select pin is not produced per character by the shifter. It follows a select bit that the writer holds in a command register. The engine therefore keeps the slave selected across any number of back-to-back characters, and releases it only after the writer clears the bit and the character in flight has finished.

The select bit can be written in three ways:
- a byte write to the command address;
- a 16-bit write to the data address, whose high byte carries the select bit alongside the first character;
- a dedicated command-port strobe from a DMA engine.

A mode register holds a 3-bit select-mode field; only the value 000 (register-driven select) is implemented. It also holds the clock polarity, the clock phase and an 8-bit clock divisor. Received characters land in a receive register with a full flag.

Top module: `spi_sel_master`

## Requirements
- R1: The slave is only selected while the select-mode field (mode register bits [2:0]) equals 000. With any other value, ss_n stays high and SCK does not toggle, whatever the select bit holds.
- R2: ss_n is active low. One clock after the select bit becomes 1 in mode 000, ss_n goes low. One clock after the bit is cleared with no character shifting, ss_n returns high.
- R3: A write to the data address (0) with both byte enables loads wdata[7:0] as a character and wdata[8] as the select bit in the same access. A byte write of wdata[0] to the command address (1) also sets the select bit, and reading address 1 returns it in bit 0.
- R4: A strobe on cmd_we loads cmd_sel into the select bit; a register-bus write of the bit in the same cycle takes priority.
- R5: ss_n stays low without a pulse across consecutive characters. SCK gives exactly 16 edges per character, and only while ss_n is low.
- R6: Characters move most significant bit first, both on MOSI and into the receive register from MISO.
- R7: SCK idles at the clock polarity bit (mode bit 3): low for 0, high for 1.
- R8: With phase (mode bit 4) at 0, the first SCK edge of each bit samples and the second shifts. With phase at 1, the first edge shifts and the second samples.
- R9: Each SCK half-period lasts div+1 system clocks, where div is mode bits [15:8].
- R10: Clearing the select bit while a character is shifting keeps ss_n low until that character has completed, then releases it.
- R11: A one-entry holding register lets the next character start with no extra gap. Status bit 1 at address 3 shows it full, and status bit 0 shows the shifter busy.
- R12: Each completed character is latched into the receive register (read at address 0, bits [7:0]) and sets status bit 2. Reading address 0 clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata valid the next cycle |
| addr | input | 2 | Register address: 0 data, 1 command, 2 mode, 3 status |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables for wdata |
| rdata | output | 16 | Registered read data |
| cmd_we | input | 1 | DMA command strobe |
| cmd_sel | input | 1 | Select value carried by the DMA command |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |

## Verification
Two-character transactions run in all four polarity and phase combinations, each with its own divisor and asymmetric byte pairs. A swapped bit order, a wrong sampling edge or a wrong idle level therefore each corrupt a different observed byte or level. An edge-timing monitor measures every SCK interval, including the one between characters. It tells a correct divisor from an off-by-one and detects any gap at the character boundary. The bench clears the select bit in the middle of the second character and counts SS transitions, which separates a deferred release from an immediate one or a per-character pulse. Directed tests drive a non-zero mode field, the DMA command port and the reset state.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_CMD  = 2'd1;
  localparam logic [1:0] ADR_MODE = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;
  localparam logic [2:0] SELMODE_REG = 3'b000;
  localparam int ST_BUSY = 0;
  localparam int ST_HOLD = 1;
  localparam int ST_RXF  = 2;
endpackage

// File: rtl/spi_sel_regs.sv
module spi_sel_regs
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [2*DATA_W-1:0] wdata,
  input  logic [1:0]        be,
  output logic [2*DATA_W-1:0] rdata,
  input  logic              cmd_we,
  input  logic              cmd_sel,
  output logic [2:0]        sel_mode,
  output logic              cpol,
  output logic              cpha,
  output logic [DIV_W-1:0]  div,
  output logic              sel_bit,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  input  logic              hold_take,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              busy
);
  localparam int BUS_W = 2 * DATA_W;

  logic              rx_full;
  logic [DATA_W-1:0] rx_data;
  logic wr_lo, wr_hi, wr_cmd, wr_mode, rd_data;

  assign wr_lo   = wr_en && addr == ADR_DATA && be[0];
  assign wr_hi   = wr_en && addr == ADR_DATA && be[1];
  assign wr_cmd  = wr_en && addr == ADR_CMD  && be[0];
  assign wr_mode = wr_en && addr == ADR_MODE;
  assign rd_data = rd_en && addr == ADR_DATA;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_mode  <= '0;
      cpol      <= 1'b0;
      cpha      <= 1'b0;
      div       <= '0;
      sel_bit   <= 1'b0;
      hold_full <= 1'b0;
      hold_data <= '0;
      rx_full   <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (wr_mode) begin
        sel_mode <= wdata[2:0];
        cpol     <= wdata[3];
        cpha     <= wdata[4];
        div      <= wdata[DATA_W +: DIV_W];
      end
      if (wr_hi)       sel_bit <= wdata[DATA_W];
      else if (wr_cmd) sel_bit <= wdata[0];
      else if (cmd_we) sel_bit <= cmd_sel;
      if (wr_lo) begin
        hold_data <= wdata[DATA_W-1:0];
        hold_full <= 1'b1;
      end else if (hold_take) begin
        hold_full <= 1'b0;
      end
      if (rx_done) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      case (addr)
        ADR_DATA: rdata[DATA_W-1:0] <= rx_data;
        ADR_CMD:  rdata[0] <= sel_bit;
        ADR_MODE: begin
          rdata[2:0] <= sel_mode;
          rdata[3]   <= cpol;
          rdata[4]   <= cpha;
          rdata[DATA_W +: DIV_W] <= div;
        end
        default: begin
          rdata[ST_BUSY] <= busy;
          rdata[ST_HOLD] <= hold_full;
          rdata[ST_RXF]  <= rx_full;
        end
      endcase
    end
  end

  // R3: combined write loads character and select together
  a_r3_word_write: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && wr_hi && wdata[DATA_W]) |=> (sel_bit && hold_full));
  // R4: command port alone updates the select bit
  a_r4_cmd_port: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !wr_hi && !wr_cmd) |=> (sel_bit == $past(cmd_sel)));
  // R12: finished character sets the flag, a read clears it
  a_r12_rx_set: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_full);
  a_r12_rx_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_done) |=> !rx_full);
  // R11: a data write always leaves the holding register full
  a_r11_hold_fill: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> hold_full);

  logic unused_bus;
  assign unused_bus = ^{BUS_W{1'b0}};
endmodule

// File: rtl/spi_sel_clkgen.sv
module spi_sel_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end

  // R9: the count never passes the divisor while running
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == div) |=> (cnt == '0));
endmodule

// File: rtl/spi_sel_shifter.sv
module spi_sel_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              free,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST = EDGE_W'(EDGES - 1);

  logic [EDGE_W-1:0] ecnt;
  logic              sck_ph;
  logic [DATA_W-1:0] sh, rx_sh, rx_next;
  logic              lead, is_samp, last_edge;

  assign lead      = ~ecnt[0];
  assign is_samp   = lead ^ cpha;
  assign last_edge = busy && tick && ecnt == LAST;
  assign free      = !busy || last_edge;
  assign rx_next   = {rx_sh[DATA_W-2:0], miso};
  assign sck       = sck_ph ^ cpol;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ecnt    <= '0;
      sck_ph  <= 1'b0;
      sh      <= '0;
      rx_sh   <= '0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (busy && tick) begin
        sck_ph <= ~sck_ph;
        if (is_samp) begin
          rx_sh <= rx_next;
        end else begin
          mosi <= sh[DATA_W-1];
          sh   <= sh << 1;
        end
        if (ecnt == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= is_samp ? rx_next : rx_sh;
          ecnt    <= '0;
        end else begin
          ecnt <= ecnt + EDGE_W'(1);
        end
      end
      if (start) begin
        busy   <= 1'b1;
        ecnt   <= '0;
        sck_ph <= 1'b0;
        if (cpha) begin
          sh <= load_byte;
        end else begin
          sh   <= load_byte << 1;
          mosi <= load_byte[DATA_W-1];
        end
      end
    end
  end

  // R9: SCK moves only on divider ticks
  a_r9_edge_on_tick: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(sck_ph));
  // R7: an idle shifter leaves SCK at its polarity level
  a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sck == cpol));
endmodule

// File: rtl/spi_sel_master.sv
module spi_sel_master
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          addr,
  input  logic [2*DATA_W-1:0] wdata,
  input  logic [1:0]          be,
  output logic [2*DATA_W-1:0] rdata,
  input  logic                cmd_we,
  input  logic                cmd_sel,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                ss_n
);
  logic [2:0]        sel_mode;
  logic              cpol, cpha, sel_bit, hold_full, hold_take;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] hold_data, rx_byte;
  logic              rx_done, busy, free, tick, ss_act, mode_ok;

  assign mode_ok   = (sel_mode == SELMODE_REG);
  assign hold_take = mode_ok && ss_act && sel_bit && hold_full && free;
  assign ss_n      = ~ss_act;

  always_ff @(posedge clk) begin
    if (rst) ss_act <= 1'b0;
    else     ss_act <= (mode_ok && sel_bit) || (ss_act && busy);
  end

  spi_sel_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .be(be), .rdata(rdata), .cmd_we(cmd_we),
    .cmd_sel(cmd_sel), .sel_mode(sel_mode), .cpol(cpol), .cpha(cpha),
    .div(div), .sel_bit(sel_bit), .hold_full(hold_full),
    .hold_data(hold_data), .hold_take(hold_take), .rx_done(rx_done),
    .rx_byte(rx_byte), .busy(busy)
  );

  spi_sel_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .div(div), .tick(tick)
  );

  spi_sel_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .start(hold_take), .load_byte(hold_data),
    .cpol(cpol), .cpha(cpha), .tick(tick), .miso(miso), .busy(busy),
    .free(free), .sck(sck), .mosi(mosi), .done(rx_done), .rx_byte(rx_byte)
  );

  // R1: outside mode 000 an idle link is never selected
  a_r1_mode_gate: assert property (@(posedge clk) disable iff (rst)
    (!mode_ok && ss_n) |=> ss_n);
  // R2: deselect with nothing shifting releases next cycle
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    (!ss_n && !sel_bit && !busy) |=> ss_n);
  // R10: a character in flight keeps the slave selected
  a_r10_hold_select: assert property (@(posedge clk) disable iff (rst)
    (!ss_n && busy) |=> !ss_n);
  // R5: shifting happens only under select
  a_r5_busy_selected: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ss_n);
endmodule

// File: tb/tb_spi_sel_master.sv
module tb_spi_sel_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [7:0] div;
    logic [7:0] m0;
    logic [7:0] m1;
    logic [7:0] s0;
    logic [7:0] s1;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b0, 1'b0, 8'd2, 8'hA5, 8'h3C, 8'h96, 8'h0F},
    '{1'b0, 1'b1, 8'd3, 8'h81, 8'h7E, 8'h1E, 8'hC3},
    '{1'b1, 1'b0, 8'd2, 8'h5A, 8'hE1, 8'h47, 8'hB8},
    '{1'b1, 1'b1, 8'd5, 8'h12, 8'hF0, 8'hD2, 8'h2D}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, cmd_we = 1'b0, cmd_sel = 1'b0;
  logic [1:0]  addr = 2'd0, be = 2'b00;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        sck, mosi, ss_n;
  logic        miso = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  spi_sel_master dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .be(be), .rdata(rdata), .cmd_we(cmd_we),
    .cmd_sel(cmd_sel), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  // slave model and edge monitor
  logic       cur_cpha = 1'b0;
  int         cur_div = 0;
  logic [7:0] slv_q [2];
  logic [7:0] cap [4];
  int         cap_idx = 0, slv_idx = 0;
  logic [7:0] s_tx = 8'h0, s_rx = 8'h0, nb;
  int         ecnt = 0;
  int         edges = 0, viol = 0, last_cyc = 0, ss_falls = 0, ss_rises = 0;
  int         sck_any = 0;
  logic       prev_ss = 1'b1, prev_sck = 1'b0;

  always @(sck or ss_n) begin
    if (prev_ss === 1'b1 && ss_n === 1'b0) begin
      ss_falls++;
      ecnt = 0;
      if (cur_cpha) s_tx = slv_q[0];
      else begin miso = slv_q[0][7]; s_tx = slv_q[0] << 1; end
    end else if (prev_ss === 1'b0 && ss_n === 1'b1) begin
      ss_rises++;
    end
    if (sck !== prev_sck && prev_sck !== 1'bx) sck_any++;
    if (ss_n === 1'b0 && sck !== prev_sck && prev_sck !== 1'bx) begin
      edges++;
      if (edges > 1 && (cyc - last_cyc) != cur_div + 1) viol++;
      last_cyc = cyc;
      if (((ecnt % 2) == 0) ^ cur_cpha) s_rx = {s_rx[6:0], mosi};
      else if (cur_cpha || ecnt != 15) begin miso = s_tx[7]; s_tx = s_tx << 1; end
      if (ecnt == 15) begin
        cap[cap_idx % 4] = s_rx;
        cap_idx++;
        slv_idx++;
        nb = slv_q[slv_idx % 2];
        if (cur_cpha) s_tx = nb;
        else begin miso = nb[7]; s_tx = nb << 1; end
        ecnt = 0;
      end else ecnt++;
    end
    prev_ss = ss_n;
    prev_sck = sck;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R2 reset ss_n", ss_n, 1);
    check("R7 reset sck idle", sck, 0);
    rd(2'd3, v);
    check("R11 reset status", v, 0);

    // R1: non-zero mode field blocks selection
    wr(2'd2, 16'h0005, 2'b11);
    wr(2'd1, 16'h0001, 2'b01);
    repeat (20) @(negedge clk);
    check("R1 ss_n high in mode 101", ss_n, 1);
    check("R1 no sck edges in mode 101", sck_any, 0);
    wr(2'd2, 16'h0200, 2'b11);
    @(negedge clk);
    check("R1 ss_n low after mode 000", ss_n, 0);
    // R2: release while idle
    wr(2'd1, 16'h0000, 2'b01);
    @(negedge clk);
    check("R2 ss_n release idle", ss_n, 1);
    // R2: command-register set
    wr(2'd1, 16'h0001, 2'b01);
    @(negedge clk);
    check("R2 ss_n low after select", ss_n, 0);
    rd(2'd1, v);
    check("R3 command read-back", v, 1);
    wr(2'd1, 16'h0000, 2'b01);
    @(negedge clk);

    // R4: DMA command port
    @(negedge clk); cmd_we = 1'b1; cmd_sel = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
    @(negedge clk);
    check("R4 dma select ss_n", ss_n, 0);
    rd(2'd1, v);
    check("R4 dma select bit", v, 1);
    @(negedge clk); cmd_we = 1'b1; cmd_sel = 1'b0;
    @(negedge clk); cmd_we = 1'b0;
    @(negedge clk);
    check("R4 dma deselect ss_n", ss_n, 1);
    // R4: bus write wins over the command port
    @(negedge clk);
    addr = 2'd1; wdata = 16'h0000; be = 2'b01; wr_en = 1'b1;
    cmd_we = 1'b1; cmd_sel = 1'b1;
    @(negedge clk); wr_en = 1'b0; cmd_we = 1'b0;
    @(negedge clk);
    check("R4 bus priority", ss_n, 1);

    // table of transactions
    for (int i = 0; i < 4; i++) begin
      wr(2'd2, {VEC[i].div, 3'b000, VEC[i].cpha, VEC[i].cpol, 3'b000}, 2'b11);
      @(negedge clk);
      check("R7 idle level", sck, int'(VEC[i].cpol));
      cur_cpha = VEC[i].cpha;
      cur_div = int'(VEC[i].div);
      slv_q[0] = VEC[i].s0;
      slv_q[1] = VEC[i].s1;
      cap_idx = 0; slv_idx = 0; edges = 0; viol = 0; ss_falls = 0; ss_rises = 0;
      s_rx = 8'h0;
      wr(2'd0, {8'h01, VEC[i].m0}, 2'b11);
      rd(2'd1, v);
      check("R3 word write select", v, 1);
      v = 16'h2;
      while (v[1]) rd(2'd3, v);
      wr(2'd0, {8'h00, VEC[i].m1}, 2'b01);
      v = 16'h0;
      while (!v[2]) rd(2'd3, v);
      check("R11 busy during next char", int'(v[0]), 1);
      rd(2'd0, v);
      check("R6 first rx byte", v, int'(VEC[i].s0));
      rd(2'd3, v);
      check("R12 flag cleared by read", int'(v[2]), 0);
      wr(2'd1, 16'h0000, 2'b01);
      @(negedge clk);
      check("R10 select held mid char", ss_n, 0);
      v = 16'h0;
      while (!v[2]) rd(2'd3, v);
      rd(2'd0, v);
      check("R6 second rx byte", v, int'(VEC[i].s1));
      while (ss_n !== 1'b1) @(negedge clk);
      @(negedge clk);
      check("R8 slave got first byte", cap[0], int'(VEC[i].m0));
      check("R8 slave got second byte", cap[1], int'(VEC[i].m1));
      check("R5 edges per transaction", edges, 32);
      check("R5 ss_n single fall", ss_falls, 1);
      check("R10 ss_n single rise", ss_rises, 1);
      check("R9 half-period and R11 no gap", viol, 0);
      check("R7 sck idle after", sck, int'(VEC[i].cpol));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule